// File: doc/BRIEF.md
# 100BASE-TX Receive Symbol Alignment and Carrier Sense

This block sits behind the descrambler of a 100 Mb/s twisted-pair receiver and takes one code bit per clock. While the line is idle it searches the serial stream for the start-of-stream delimiter. The delimiter is the J code-group followed by the K code-group. The position of J fixes the 5-bit symbol boundary, and every later code-group is cut on that boundary.

After K is confirmed, the block presents each following code-group on a 5-bit output with a one-cycle valid strobe. The 4B/5B nibble decoder downstream consumes these code-groups. Carrier sense rises as soon as J is seen. It falls when the end-of-stream pair T, R arrives or when the line returns to idle. If J is not followed by K, the block reports a false carrier. In half duplex, carrier sense also follows the local transmit enable.

Code bits arrive most significant bit first: bit 4 of a code-group is the first bit on the wire.

Top module: `rx_align_crs`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, crs_o, false_carrier_o, grp_valid_o and eos_o are 0.
- R2: In hunt state, a lock happens only when the last ten received bits are 11111 followed by J = 11000. After a lock, code-groups are cut every five bits, counted from the last bit of J.
- R3: rx carrier (crs_o in full duplex) is 1 in the cycle after the clock edge that samples the last bit of J.
- R4: After K = 10001 is confirmed, each further code-group appears on grp_o with grp_valid_o high for one cycle. This happens in the cycle after its last bit, so the strobe comes at most once every five cycles. J, K, T and R are never strobed.
- R5: If the code-group after J is not K, false_carrier_o pulses for exactly one cycle and carrier drops in that same cycle. No data is strobed. No new lock is taken until ten consecutive 1 bits have been received.
- R6: T = 01101 followed by R = 00111 ends the stream. Carrier drops and eos_o pulses for one cycle in the cycle after R's last bit. A T that is not followed by R is discarded, and the code-group after it is treated as ordinary data.
- R7: Two consecutive 11111 code-groups inside a stream end it: carrier drops in the cycle after the second one. A single 11111 is strobed as data, but the second one is not.
- R8: With full_duplex_i = 0, crs_o is 1 whenever tx_en_i is 1. With full_duplex_i = 1, tx_en_i has no effect on crs_o.
- R9: A J pattern preceded by fewer than five 1 bits gives no lock, no carrier and no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Descrambled received code bit |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_en_i | input | 1 | Local transmit enable |
| crs_o | output | 1 | Carrier sense |
| false_carrier_o | output | 1 | One-cycle false-carrier pulse |
| grp_o | output | 5 | Aligned code-group |
| grp_valid_o | output | 1 | grp_o holds a data code-group |
| eos_o | output | 1 | One-cycle pulse on end-of-stream T/R |

## Verification
The assertions check, on every cycle, several properties:
- false-carrier and end-of-stream events are single-cycle pulses;
- a data strobe never coincides with an end-of-stream pulse;
- in full duplex, a strobe always comes with carrier;
- in full duplex, carrier is low during a false-carrier or end-of-stream pulse.

Alignment at arbitrary bit offsets, the exact cycle in which carrier rises and falls, and discarding of a stray T depend on the bit history. The bench's reference model shows those by replaying whole packets, bad delimiters, idle-terminated streams and unqualified J patterns.

// File: rtl/rx_align_pkg.sv
package rx_align_pkg;
  localparam int SYM_W = 5;
  localparam int WIN_W = 2 * SYM_W;
  localparam int CNT_W = $clog2(SYM_W);

  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_CONFIRM,
    ST_STREAM,
    ST_REJECT
  } rx_state_e;
endpackage

// File: rtl/rx_bit_window.sv
module rx_bit_window
  import rx_align_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output sym_t             grp_o,
  output logic             sof_hit_o,
  output logic             all_idle_o
);
  logic [WIN_W-2:0] hist_q;
  logic [WIN_W-1:0] win_next;

  assign win_next   = {hist_q, bit_i};
  assign grp_o      = win_next[SYM_W-1:0];
  assign sof_hit_o  = (win_next == {SYM_IDLE, SYM_J});
  assign all_idle_o = &win_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= win_next[WIN_W-2:0];
  end
endmodule

// File: rtl/rx_sym_counter.sv
module rx_sym_counter
  import rx_align_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (done_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_stream_fsm.sv
module rx_stream_fsm
  import rx_align_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_hit_i,
  input  logic grp_done_i,
  input  sym_t grp_i,
  input  logic all_idle_i,
  output logic hunting_o,
  output logic rx_carrier_o,
  output sym_t grp_o,
  output logic grp_valid_o,
  output logic false_carrier_o,
  output logic eos_o
);
  rx_state_e state_q;
  logic      t_pend_q;
  logic      idle_pend_q;

  assign hunting_o    = (state_q == ST_HUNT);
  assign rx_carrier_o = (state_q == ST_CONFIRM) || (state_q == ST_STREAM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_HUNT;
      t_pend_q        <= 1'b0;
      idle_pend_q     <= 1'b0;
      grp_o           <= '0;
      grp_valid_o     <= 1'b0;
      false_carrier_o <= 1'b0;
      eos_o           <= 1'b0;
    end else begin
      grp_valid_o     <= 1'b0;
      false_carrier_o <= 1'b0;
      eos_o           <= 1'b0;
      unique case (state_q)
        ST_HUNT: if (sof_hit_i) state_q <= ST_CONFIRM;
        ST_CONFIRM: if (grp_done_i) begin
          t_pend_q    <= 1'b0;
          idle_pend_q <= 1'b0;
          if (grp_i == SYM_K) begin
            state_q <= ST_STREAM;
          end else begin
            state_q         <= ST_REJECT;
            false_carrier_o <= 1'b1;
          end
        end
        ST_STREAM: if (grp_done_i) begin
          if (t_pend_q && grp_i == SYM_R) begin
            state_q <= ST_HUNT;
            eos_o   <= 1'b1;
          end else if (idle_pend_q && grp_i == SYM_IDLE) begin
            state_q <= ST_HUNT;
          end else if (grp_i == SYM_T) begin
            t_pend_q    <= 1'b1;
            idle_pend_q <= 1'b0;
          end else begin
            grp_o       <= grp_i;
            grp_valid_o <= 1'b1;
            t_pend_q    <= 1'b0;
            idle_pend_q <= (grp_i == SYM_IDLE);
          end
        end
        ST_REJECT: if (all_idle_i) state_q <= ST_HUNT;
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/rx_align_crs.sv
module rx_align_crs
  import rx_align_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             full_duplex_i,
  input  logic             tx_en_i,
  output logic             crs_o,
  output logic             false_carrier_o,
  output logic [SYM_W-1:0] grp_o,
  output logic             grp_valid_o,
  output logic             eos_o
);
  sym_t win_grp;
  logic sof_hit, all_idle, grp_done, hunting, rx_carrier;

  rx_bit_window u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (rx_bit_i),
    .grp_o      (win_grp),
    .sof_hit_o  (sof_hit),
    .all_idle_o (all_idle)
  );

  // boundary restarts on the lock so the next group is K
  rx_sym_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sof_hit & hunting),
    .done_o (grp_done)
  );

  rx_stream_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sof_hit_i       (sof_hit),
    .grp_done_i      (grp_done),
    .grp_i           (win_grp),
    .all_idle_i      (all_idle),
    .hunting_o       (hunting),
    .rx_carrier_o    (rx_carrier),
    .grp_o           (grp_o),
    .grp_valid_o     (grp_valid_o),
    .false_carrier_o (false_carrier_o),
    .eos_o           (eos_o)
  );

  assign crs_o = rx_carrier | (~full_duplex_i & tx_en_i);
endmodule

// File: rtl/rx_align_crs_chk.sv
module rx_align_crs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic full_duplex_i,
  input logic crs_o,
  input logic false_carrier_o,
  input logic grp_valid_o,
  input logic eos_o
);
  // R5
  fc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    false_carrier_o |=> !false_carrier_o);
  // R5
  fc_no_crs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (false_carrier_o && full_duplex_i) |-> !crs_o);
  // R4
  valid_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |=> !grp_valid_o);
  // R4
  valid_crs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_valid_o && full_duplex_i) |-> crs_o);
  // R6
  eos_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o);
  // R6
  eos_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_o && full_duplex_i) |-> !crs_o);
  // R6
  eos_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |-> !grp_valid_o);
endmodule

bind rx_align_crs rx_align_crs_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .full_duplex_i   (full_duplex_i),
  .crs_o           (crs_o),
  .false_carrier_o (false_carrier_o),
  .grp_valid_o     (grp_valid_o),
  .eos_o           (eos_o)
);

// File: tb/rx_align_crs_tb_top.sv
`timescale 1ns/1ps
module rx_align_crs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1;
  logic fd = 1'b1;
  logic tx_en = 1'b0;
  logic crs, fc, gval, eos;
  logic [4:0] grp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_align_crs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .full_duplex_i(fd),
    .tx_en_i(tx_en), .crs_o(crs), .false_carrier_o(fc), .grp_o(grp),
    .grp_valid_o(gval), .eos_o(eos)
  );

  // reference model: 0 hunt, 1 confirm, 2 stream, 3 reject
  int  m_mode = 0;
  int  m_bits = 0;
  bit  m_hist[$];
  bit  m_t = 0, m_i = 0;
  bit  e_fc, e_val, e_eos;
  logic [4:0] e_grp;
  logic [4:0] got_q[$];
  int  n_fc = 0, n_eos = 0;

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endfunction

  function automatic int hist_val(int n);
    int v = 0;
    for (int i = m_hist.size() - n; i < m_hist.size(); i++) v = (v << 1) | int'(m_hist[i]);
    return v;
  endfunction

  function automatic void model_step(bit b);
    int g;
    m_hist.push_back(b);
    if (m_hist.size() > 10) void'(m_hist.pop_front());
    e_fc = 0; e_val = 0; e_eos = 0;
    case (m_mode)
      0: if (m_hist.size() == 10 && hist_val(10) == 10'b1111111000) begin
           m_mode = 1; m_bits = 0;
         end
      1: begin
           m_bits++;
           if (m_bits == 5) begin
             m_bits = 0; m_t = 0; m_i = 0;
             if (hist_val(5) == 5'b10001) m_mode = 2;
             else begin m_mode = 3; e_fc = 1; end
           end
         end
      2: begin
           m_bits++;
           if (m_bits == 5) begin
             m_bits = 0;
             g = hist_val(5);
             if (m_t && g == 5'b00111) begin m_mode = 0; e_eos = 1; end
             else if (m_i && g == 5'b11111) m_mode = 0;
             else if (g == 5'b01101) begin m_t = 1; m_i = 0; end
             else begin e_val = 1; e_grp = 5'(g); m_t = 0; m_i = (g == 31); end
           end
         end
      default: if (m_hist.size() == 10 && hist_val(10) == 1023) m_mode = 0;
    endcase
  endfunction

  function automatic void compare();
    bit e_crs;
    e_crs = (m_mode == 1 || m_mode == 2) || (!fd && tx_en);
    chk(crs == e_crs, "R3/R8 crs", int'(crs), int'(e_crs));
    chk(fc == e_fc, "R5 false_carrier", int'(fc), int'(e_fc));
    chk(gval == e_val, "R4 grp_valid", int'(gval), int'(e_val));
    chk(eos == e_eos, "R6 eos", int'(eos), int'(e_eos));
    if (gval && e_val) chk(grp == e_grp, "R2 grp", int'(grp), int'(e_grp));
    if (gval) got_q.push_back(grp);
    if (fc) n_fc++;
    if (eos) n_eos++;
  endfunction

  task automatic send_bit(bit b);
    @(negedge clk);
    rx_bit = b;
    @(posedge clk);
    #1;
    model_step(b);
    compare();
  endtask

  task automatic send_grp(logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_run(bit b, int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic expect_data(logic [4:0] exp_q[$], string req);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, int'(got_q[i]), int'(exp_q[i]));
    got_q.delete();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] exp_q[$];
    // R1
    repeat (3) @(posedge clk);
    #1;
    chk({crs, fc, gval, eos} == 4'b0, "R1 reset outputs", int'({crs, fc, gval, eos}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk({crs, fc, gval, eos} == 4'b0, "R1 after release", int'({crs, fc, gval, eos}), 0);

    // R2 R3 R4 R6: full packet at odd offset
    send_run(1, 23);
    send_grp(5'b11000);
    chk(crs == 1'b1, "R3 crs after J", int'(crs), 1);
    send_grp(5'b10001);
    send_grp(5'h0E); send_grp(5'h09); send_grp(5'h1E); send_grp(5'h15); send_grp(5'h0A);
    send_grp(5'b01101); send_grp(5'b00111);
    chk(crs == 1'b0 && n_eos == 1, "R6 end by T/R", int'(n_eos), 1);
    exp_q = '{5'h0E, 5'h09, 5'h1E, 5'h15, 5'h0A};
    expect_data(exp_q, "R4 packet data");
    send_run(1, 17);

    // R5: J then non-K, J pattern before ten ones ignored
    send_grp(5'b11000);
    send_grp(5'b10101);
    chk(n_fc == 1, "R5 false carrier count", n_fc, 1);
    send_run(1, 5); send_grp(5'b11000); send_grp(5'b10001);
    chk(crs == 1'b0, "R5 no relock", int'(crs), 0);
    send_run(1, 12);
    send_grp(5'b11000); send_grp(5'b10001); send_grp(5'h0E);
    send_grp(5'b01101); send_grp(5'b00111);
    exp_q = '{5'h0E};
    expect_data(exp_q, "R5 recovery packet");
    send_run(1, 9);

    // R7: idle inside stream
    send_grp(5'b11000); send_grp(5'b10001);
    send_grp(5'h0E); send_grp(5'h1F); send_grp(5'h09);
    send_grp(5'h1F); send_grp(5'h1F);
    chk(crs == 1'b0, "R7 crs after two idles", int'(crs), 0);
    exp_q = '{5'h0E, 5'h1F, 5'h09, 5'h1F};
    expect_data(exp_q, "R7 idle data");
    send_run(1, 11);

    // R6: stray T discarded
    send_grp(5'b11000); send_grp(5'b10001);
    send_grp(5'h0E); send_grp(5'b01101); send_grp(5'h09);
    send_grp(5'b01101); send_grp(5'b00111);
    exp_q = '{5'h0E, 5'h09};
    expect_data(exp_q, "R6 stray T");
    send_run(1, 8);

    // R9: J with too few leading ones
    send_run(0, 10); send_run(1, 4);
    send_grp(5'b11000); send_grp(5'b10001); send_grp(5'h0E);
    chk(crs == 1'b0, "R9 no lock crs", int'(crs), 0);
    exp_q = '{};
    expect_data(exp_q, "R9 no data");
    send_run(1, 10);

    // R8: duplex vs transmit enable
    fd = 1'b0; tx_en = 1'b1;
    send_run(1, 4);
    chk(crs == 1'b1, "R8 half duplex tx", int'(crs), 1);
    fd = 1'b1;
    send_run(1, 4);
    chk(crs == 1'b0, "R8 full duplex ignores tx", int'(crs), 0);
    fd = 1'b0;
    send_grp(5'b11000); send_grp(5'b10001); send_grp(5'h0E);
    tx_en = 1'b0;
    send_grp(5'h09); send_grp(5'b01101); send_grp(5'b00111);
    send_run(1, 6);
    chk(crs == 1'b0, "R8 half duplex idle", int'(crs), 0);
    exp_q = '{5'h0E, 5'h09};
    expect_data(exp_q, "R8 half duplex packet");
    fd = 1'b1;
    send_run(1, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule